// File: doc/BRIEF.md
# Dual-Output Waveform Timer Channel

This block is one timer channel that produces two pulse-width-modulated outputs, A and B, from a single up-counter. The counter advances on enable pulses from one of several prescaled tick sources, chosen by a field of the mode register. It returns to zero when it reaches the period value. Both outputs therefore share one period. Each output has its own compare value and its own set of actions. An action can be applied on the output's compare match, on the period match, or on a software trigger. With these actions an output can run as a normal or inverted PWM, toggle, or hold a fixed level.

Software programs the channel through a simple write port with five addresses: mode, compare A, compare B, period and command. A typical start sequence has three steps. First stop the channel. Then write the mode, compare and period values. Finally write start together with trigger, which zeroes the counter and sets both outputs to their trigger levels in the same cycle. Writing stop together with trigger parks both outputs at their trigger levels and freezes the counter.

Top module: `wavetmr_chan`

## Requirements
- R1: After reset both outputs are low, the counter is zero and the channel is stopped. While stopped, the counter does not move and no compare or period action fires.
- R2: While running, the counter increments by one on each selected tick. On a tick where it equals the period value it returns to zero instead, so one cycle lasts period+1 ticks and both outputs use that same cycle.
- R3: Mode bits [2:0] select which bit of `tick_in` advances the counter. Ticks on the other bits have no effect.
- R4: The write port decodes five addresses: 0 mode, 1 compare A, 2 compare B, 3 period, 4 command. Compare and period values take the low CNT_W bits of the write data.
- R5: Mode fields: [4:3] A compare action, [6:5] A period action, [8:7] A trigger action, [10:9] B compare action, [12:11] B period action, [14:13] B trigger action. Action codes: 00 none, 01 set, 10 clear, 11 toggle.
- R6: Normal PWM uses compare=clear, period=set, trigger=set. With compare C and period P, the output in sample i after start is high when (i mod (P+1)) <= C. Inverted PWM uses compare=set, period=clear, trigger=clear, and the output is high when (i mod (P+1)) > C.
- R7: A software trigger clears the counter and applies each output's trigger action in the same cycle. It takes priority over any period or compare event on that edge.
- R8: Command bits: bit0 start, bit1 stop, bit2 trigger. Stop wins over start when both are written together. Stop with trigger forces the trigger levels and holds them. Start alone resumes from the held count without changing either output.
- R9: When the period match and an output's compare match fall on the same tick, only the period action applies, even if that action is none.
- R10: While running, a compare write takes effect at the next counter wrap or the next software trigger. While stopped, it takes effect at once.
- R11: An output whose compare and period actions are both none keeps its trigger level for as long as the channel runs.
- R12: The toggle code inverts the output on each occurrence of its event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address (0 mode, 1 compare A, 2 compare B, 3 period, 4 command) |
| wr_data | input | DATA_W | Write data |
| tick_in | input | NUM_CLK | Prescaled tick enables, one per clock-select value |
| pwm_a | output | 1 | Output A, registered |
| pwm_b | output | 1 | Output B, registered |

## Verification
A command or register write is sampled on the rising edge that follows its set-up. The edge that accepts a start-with-trigger is called edge 0. Its effect is visible at the next falling edge, and that sample is counted as sample 0. A compare or period event changes an output on the same edge that sees the matching count, so sample i reflects every event up to edge i. Every expectation is written as a function of i, the compare value and the period. The bench issues each stimulus at a falling edge, samples every output at the following falling edges, and aligns mid-run writes, such as the trigger that collides with a compare match, to a known sample index. Where the tick phase is not known, the bench first skips one full cycle and then counts high samples over whole periods.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
package wtc_pkg;

  localparam int CLKSEL_W = 3;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TOG  = 2'b11
  } act_e;

  typedef struct packed {
    act_e                b_sw;
    act_e                b_per;
    act_e                b_cmp;
    act_e                a_sw;
    act_e                a_per;
    act_e                a_cmp;
    logic [CLKSEL_W-1:0] clk_sel;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  localparam logic [2:0] ADDR_MODE = 3'd0;
  localparam logic [2:0] ADDR_CMPA = 3'd1;
  localparam logic [2:0] ADDR_CMPB = 3'd2;
  localparam logic [2:0] ADDR_PER  = 3'd3;
  localparam logic [2:0] ADDR_CMD  = 3'd4;

  localparam int CMD_START = 0;
  localparam int CMD_STOP  = 1;
  localparam int CMD_TRIG  = 2;

  function automatic logic apply_act(input logic cur, input act_e a);
    case (a)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TOG: return ~cur;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/wtc_regs.sv
`timescale 1ns/1ps
module wtc_regs
  import wtc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        cmp_load,
  output mode_t                       mode_q,
  output logic [CNT_W-1:0]            per_q,
  output logic [1:0][CNT_W-1:0]       cmp_live,
  output logic                        cmd_start,
  output logic                        cmd_stop,
  output logic                        cmd_trig
);

  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ADDR_MODE);
  localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(ADDR_PER);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(ADDR_CMD);

  logic sel_cmd;
  assign sel_cmd   = wr_en && (wr_addr == A_CMD);
  assign cmd_start = sel_cmd && wr_data[CMD_START];
  assign cmd_stop  = sel_cmd && wr_data[CMD_STOP];
  assign cmd_trig  = sel_cmd && wr_data[CMD_TRIG];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      per_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_MODE) mode_q <= mode_t'(wr_data[MODE_W-1:0]);
      if (wr_addr == A_PER)  per_q  <= wr_data[CNT_W-1:0];
    end
  end

  // Compare registers: written into a shadow, copied to the live value
  // at the counter wrap, on a trigger, or continuously while stopped.
  for (genvar g = 0; g < 2; g++) begin : g_cmp
    localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(int'(ADDR_CMPA) + g);
    logic [CNT_W-1:0] shadow_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_q <= '0;
      end else if (wr_en && (wr_addr == A_CMP)) begin
        shadow_q <= wr_data[CNT_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_live[g] <= '0;
      end else if (cmp_load) begin
        cmp_live[g] <= shadow_q;
      end
    end
  end

endmodule

// File: rtl/wtc_counter.sv
`timescale 1ns/1ps
module wtc_counter
  import wtc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_CLK = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_CLK-1:0]    tick_in,
  input  logic [CLKSEL_W-1:0]   clk_sel,
  input  logic [CNT_W-1:0]      per,
  input  logic [1:0][CNT_W-1:0] cmp_live,
  input  logic                  cmd_start,
  input  logic                  cmd_stop,
  input  logic                  cmd_trig,
  output logic [CNT_W-1:0]      cnt,
  output logic                  run,
  output logic                  tick,
  output logic                  evt_per,
  output logic [1:0]            evt_cmp,
  output logic                  cmp_load
);

  logic step;

  always_comb begin
    tick = 1'b0;
    for (int k = 0; k < NUM_CLK; k++) begin
      if (clk_sel == CLKSEL_W'(k)) tick = tick_in[k];
    end
  end

  assign step     = run && tick && !cmd_trig;
  assign evt_per  = step && (cnt == per);
  assign cmp_load = evt_per || cmd_trig || !run;

  for (genvar g = 0; g < 2; g++) begin : g_evt
    assign evt_cmp[g] = step && (cnt == cmp_live[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
    end else if (cmd_stop) begin
      run <= 1'b0;
    end else if (cmd_start) begin
      run <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cmd_trig || evt_per) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/wtc_outlogic.sv
`timescale 1ns/1ps
module wtc_outlogic
  import wtc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic evt_per,
  input  logic evt_cmp,
  input  act_e act_sw,
  input  act_e act_per,
  input  act_e act_cmp,
  output logic level
);

  logic level_d;

  // Priority: trigger, then period match, then own compare.
  always_comb begin
    if (trig) begin
      level_d = apply_act(level, act_sw);
    end else if (evt_per) begin
      level_d = apply_act(level, act_per);
    end else if (evt_cmp) begin
      level_d = apply_act(level, act_cmp);
    end else begin
      level_d = level;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) level <= 1'b0;
    else     level <= level_d;
  end

endmodule

// File: rtl/wavetmr_chan.sv
`timescale 1ns/1ps
module wavetmr_chan
  import wtc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3,
  parameter int NUM_CLK = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NUM_CLK-1:0] tick_in,
  output logic              pwm_a,
  output logic              pwm_b
);

  mode_t                  mode_q;
  logic [CNT_W-1:0]       per_q;
  logic [1:0][CNT_W-1:0]  cmp_live;
  logic                   cmd_start;
  logic                   cmd_stop;
  logic                   cmd_trig;
  logic [CNT_W-1:0]       cnt;
  logic                   run;
  logic                   tick;
  logic                   evt_per;
  logic [1:0]             evt_cmp;
  logic                   cmp_load;
  logic [1:0]             pwm_q;
  act_e                   act_sw  [2];
  act_e                   act_per [2];
  act_e                   act_cmp [2];

  assign act_sw[0]  = mode_q.a_sw;
  assign act_per[0] = mode_q.a_per;
  assign act_cmp[0] = mode_q.a_cmp;
  assign act_sw[1]  = mode_q.b_sw;
  assign act_per[1] = mode_q.b_per;
  assign act_cmp[1] = mode_q.b_cmp;

  wtc_regs #(
    .CNT_W (CNT_W),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cmp_load (cmp_load),
    .mode_q   (mode_q),
    .per_q    (per_q),
    .cmp_live (cmp_live),
    .cmd_start(cmd_start),
    .cmd_stop (cmd_stop),
    .cmd_trig (cmd_trig)
  );

  wtc_counter #(
    .CNT_W  (CNT_W),
    .NUM_CLK(NUM_CLK)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick_in  (tick_in),
    .clk_sel  (mode_q.clk_sel),
    .per      (per_q),
    .cmp_live (cmp_live),
    .cmd_start(cmd_start),
    .cmd_stop (cmd_stop),
    .cmd_trig (cmd_trig),
    .cnt      (cnt),
    .run      (run),
    .tick     (tick),
    .evt_per  (evt_per),
    .evt_cmp  (evt_cmp),
    .cmp_load (cmp_load)
  );

  for (genvar g = 0; g < 2; g++) begin : g_out
    wtc_outlogic u_out (
      .clk    (clk),
      .rst    (rst),
      .trig   (cmd_trig),
      .evt_per(evt_per),
      .evt_cmp(evt_cmp[g]),
      .act_sw (act_sw[g]),
      .act_per(act_per[g]),
      .act_cmp(act_cmp[g]),
      .level  (pwm_q[g])
    );
  end

  assign pwm_a = pwm_q[0];
  assign pwm_b = pwm_q[1];

endmodule

// File: rtl/wtc_chan_chk.sv
`timescale 1ns/1ps
module wtc_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             tick,
  input logic             trg,
  input logic             stop,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per,
  input logic             evt_per,
  input logic [1:0]       evt_cmp,
  input logic             pwm_a,
  input logic             pwm_b
);

  // R1: reset leaves outputs low, counter zero, channel stopped
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!pwm_a && !pwm_b && cnt == '0 && !run));

  // R1: a stopped channel holds its count unless triggered
  a_r1_hold_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run && !trg) |=> $stable(cnt));

  // R2: counting up on a selected tick below the period
  a_r2_count_up: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !trg && cnt != per) |=> (cnt == $past(cnt) + 1'b1));

  // R2: return to zero at the period value
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !trg && cnt == per) |=> (cnt == '0));

  // R7: trigger clears the counter
  a_r7_trig_clears: assert property (@(posedge clk) disable iff (rst)
    trg |=> (cnt == '0));

  // R8: stop command halts the channel
  a_r8_stop_halts: assert property (@(posedge clk) disable iff (rst)
    stop |=> !run);

  // R11: outputs change only on an event or trigger
  a_r11_quiet_a: assert property (@(posedge clk) disable iff (rst)
    (!trg && !evt_per && !evt_cmp[0]) |=> $stable(pwm_a));

  a_r11_quiet_b: assert property (@(posedge clk) disable iff (rst)
    (!trg && !evt_per && !evt_cmp[1]) |=> $stable(pwm_b));

endmodule

bind wavetmr_chan wtc_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .run    (run),
  .tick   (tick),
  .trg    (cmd_trig),
  .stop   (cmd_stop),
  .cnt    (cnt),
  .per    (per_q),
  .evt_per(evt_per),
  .evt_cmp(evt_cmp),
  .pwm_a  (pwm_a),
  .pwm_b  (pwm_b)
);

// File: tb/wavetmr_chan_tb.sv
`timescale 1ns/1ps
module wavetmr_chan_tb;

  localparam logic [1:0] NONE = 2'b00, SET = 2'b01, CLR = 2'b10, TOG = 2'b11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        half = 1'b0;
  logic [7:0]  tick_in;
  logic        pwm_a, pwm_b;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  assign tick_in = {6'b0, half, 1'b1};

  always #2.5 clk = ~clk;
  always @(negedge clk) half <= ~half;

  wavetmr_chan u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick_in(tick_in), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  task automatic chk(input string req, input int idx, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s sample %0d: actual %b expected %b", req, idx, got, exp);
    end
  endtask

  task automatic chk_n(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] mk_mode(input logic [2:0] sel,
      input logic [1:0] ac, input logic [1:0] ap, input logic [1:0] as,
      input logic [1:0] bc, input logic [1:0] bp, input logic [1:0] bs);
    return {1'b0, bs, bp, bc, as, ap, ac, sel};
  endfunction

  // stop, program, then start+trigger; returns at sample 0
  task automatic start(input logic [15:0] mode, input logic [15:0] ca,
                       input logic [15:0] cb, input logic [15:0] per);
    wr(3'd4, 16'h0002);
    wr(3'd0, mode);
    wr(3'd1, ca);
    wr(3'd2, cb);
    wr(3'd3, per);
    wr(3'd4, 16'h0005);
  endtask

  task automatic t_reset;
    chk("R1", 0, pwm_a, 1'b0);
    chk("R1", 0, pwm_b, 1'b0);
    wr(3'd0, mk_mode(3'd0, SET, SET, NONE, SET, SET, NONE));
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R1", i, pwm_a, 1'b0);
      chk("R1", i, pwm_b, 1'b0);
    end
  endtask

  task automatic t_normal;
    start(mk_mode(3'd0, CLR, SET, SET, CLR, SET, SET), 16'd1, 16'd3, 16'd4);
    for (int i = 0; i < 15; i++) begin
      if (i > 0) @(negedge clk);
      chk("R6", i, pwm_a, (i % 5) <= 1);
      chk("R2", i, pwm_b, (i % 5) <= 3);
    end
  endtask

  task automatic t_inverted;
    start(mk_mode(3'd0, SET, CLR, CLR, CLR, SET, SET), 16'd2, 16'd0, 16'd6);
    for (int i = 0; i < 14; i++) begin
      if (i > 0) @(negedge clk);
      chk("R5", i, pwm_a, (i % 7) > 2);
      chk("R4", i, pwm_b, (i % 7) <= 0);
    end
  endtask

  task automatic t_clksel;
    int ha, hb;
    start(mk_mode(3'd2, CLR, SET, SET, CLR, SET, SET), 16'd1, 16'd3, 16'd4);
    for (int i = 0; i < 20; i++) begin
      if (i > 0) @(negedge clk);
      chk("R3", i, pwm_a, 1'b1);
    end
    start(mk_mode(3'd1, CLR, SET, SET, CLR, SET, SET), 16'd1, 16'd3, 16'd4);
    repeat (12) @(negedge clk);
    ha = 0; hb = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      ha += int'(pwm_a);
      hb += int'(pwm_b);
    end
    chk_n("R3 half-rate A highs", ha, 16);
    chk_n("R3 half-rate B highs", hb, 32);
  endtask

  task automatic t_priority;
    start(mk_mode(3'd0, CLR, SET, SET, TOG, NONE, CLR), 16'd3, 16'd3, 16'd3);
    for (int i = 0; i < 12; i++) begin
      if (i > 0) @(negedge clk);
      chk("R9", i, pwm_a, 1'b1);
      chk("R9", i, pwm_b, 1'b0);
    end
  endtask

  task automatic t_trigger;
    start(mk_mode(3'd0, CLR, SET, SET, SET, CLR, CLR), 16'd1, 16'd3, 16'd4);
    chk("R7", 0, pwm_a, 1'b1);
    @(negedge clk);
    chk("R7", 1, pwm_a, 1'b1);
    // trigger lands on the edge where count equals compare A
    wr(3'd4, 16'h0004);
    for (int i = 0; i < 10; i++) begin
      if (i > 0) @(negedge clk);
      chk("R7", i, pwm_a, (i % 5) <= 1);
      chk("R7", i, pwm_b, (i % 5) > 3);
    end
  endtask

  task automatic t_stop;
    start(mk_mode(3'd0, CLR, SET, SET, CLR, SET, SET), 16'd1, 16'd3, 16'd4);
    repeat (3) @(negedge clk);
    wr(3'd0, mk_mode(3'd0, CLR, SET, CLR, CLR, SET, SET));
    wr(3'd4, 16'h0006);
    for (int i = 0; i < 20; i++) begin
      if (i > 0) @(negedge clk);
      chk("R8", i, pwm_a, 1'b0);
      chk("R8", i, pwm_b, 1'b1);
    end
    @(negedge clk);
    wr(3'd4, 16'h0003);
    for (int i = 0; i < 10; i++) begin
      if (i > 0) @(negedge clk);
      chk("R8", i, pwm_a, 1'b0);
      chk("R8", i, pwm_b, 1'b1);
    end
    @(negedge clk);
    wr(3'd4, 16'h0001);
    for (int i = 0; i < 12; i++) begin
      if (i > 0) @(negedge clk);
      chk("R8", i, pwm_a, (i >= 5) && ((i % 5) <= 1));
      chk("R8", i, pwm_b, (i % 5) <= 3);
    end
  endtask

  task automatic t_buffer;
    start(mk_mode(3'd0, CLR, SET, SET, NONE, NONE, CLR), 16'd5, 16'd0, 16'd9);
    chk("R10", 0, pwm_a, 1'b1);
    wr(3'd1, 16'd2);
    for (int i = 1; i < 24; i++) begin
      if (i > 1) @(negedge clk);
      chk("R10", i, pwm_a, (i < 10) ? (i <= 5) : ((i % 10) <= 2));
    end
  endtask

  task automatic t_static;
    start(mk_mode(3'd0, NONE, NONE, SET, NONE, NONE, CLR), 16'd1, 16'd1, 16'd3);
    for (int i = 0; i < 12; i++) begin
      if (i > 0) @(negedge clk);
      chk("R11", i, pwm_a, 1'b1);
      chk("R11", i, pwm_b, 1'b0);
    end
    start(mk_mode(3'd0, NONE, NONE, CLR, NONE, NONE, SET), 16'd1, 16'd1, 16'd3);
    for (int i = 0; i < 12; i++) begin
      if (i > 0) @(negedge clk);
      chk("R11", i, pwm_a, 1'b0);
      chk("R11", i, pwm_b, 1'b1);
    end
  endtask

  task automatic t_toggle;
    start(mk_mode(3'd0, TOG, NONE, CLR, NONE, TOG, SET), 16'd0, 16'd2, 16'd3);
    for (int i = 0; i < 16; i++) begin
      if (i > 0) @(negedge clk);
      chk("R12", i, pwm_a, logic'(((i + 3) / 4) % 2));
      chk("R12", i, pwm_b, logic'(1 - ((i / 4) % 2)));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_inverted();
    t_clksel();
    t_priority();
    t_trigger();
    t_stop();
    t_buffer();
    t_static();
    t_toggle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule